// File: doc/BRIEF.md
# Two-Button Sequential Password Lock

The block checks a password of four symbols. Each symbol is 2 bits wide and comes from two push buttons. The symbol on the buttons is read only in a cycle where a single-cycle strobe input is high. The block assumes the strobe is already debounced.

When all four symbols are correct, the lock reaches its open state and raises `open_o`. In the host system, that output enables the display of election results. If any symbol is wrong, the lock enters an error chain. It still takes one step per strobe until four symbols have been entered, so a wrong entry cannot be detected early from the outputs. After the fourth symbol it raises `error_o`.

Both final states hold until `restart` is asserted or the block is reset. Either one returns the lock to its start state.

Top module: `seq_code_lock`

## Requirements
- R1: After reset (active-low `rst_n`), the lock is at the start with zero symbols taken, and `open_o` and `error_o` are both 0.
- R2: A symbol is `{keys[1], keys[0]}`. Symbol i of the password is held in bits `[i*SYM_W +: SYM_W]` of `CODE`. The default password, in the order it is entered, is 10, 01, 11, 00. After four correct strobed symbols, `open_o` is 1 and `error_o` is 0, starting on the clock edge that samples the fourth strobe.
- R3: Each strobe outside a final state advances the lock by exactly one symbol. Cycles without a strobe change nothing.
- R4: A wrong symbol at any step moves the lock into the error chain. `open_o` stays 0 for the rest of that attempt.
- R5: `error_o` is 1 only once four symbols of a failed attempt have been taken. Before that, both outputs are 0. The two outputs are never 1 together.
- R6: Once a symbol has been wrong, the remaining symbols of the attempt are taken without regard to their value, including symbols that match the password.
- R7: In either final state (open or error), strobes are ignored and the outputs hold.
- R8: `restart` in a final state returns the lock to the start, with both outputs 0, on the next edge. If a strobe arrives in the same cycle, it is not counted.
- R9: `restart` before a final state is reached is ignored, and the attempt continues where it was.
- R10: The outputs are registered and follow the state: `open_o` goes with the final correct state, and `error_o` goes with the final error state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Single-cycle pulse that samples `keys` |
| keys | input | SYM_W | Button symbol; bit 1 is the high button, bit 0 the low button |
| restart | input | 1 | Returns the lock to the start from a final state |
| open_o | output | 1 | Password accepted |
| error_o | output | 1 | Failed attempt completed |

## Verification
The bench puts a wrong symbol first, last and in the middle of an attempt. It then feeds correct symbols after the mistake. A design that resets on error, or that treats a later correct symbol as a new start, would raise `error_o` too early or never raise it.

It strobes inside both final states and asserts `restart` before a final state. A lock that takes those actions would leave its final state or drop a partial entry, and a later correct tail would then fail to open it.

A restart together with a strobe, followed by a complete password, shows whether the strobe was wrongly counted as a first symbol. Idle cycles between symbols expose a lock that moves without a strobe.

// File: rtl/lock_pkg.sv
package lock_pkg;
  // Width of the step counter; supports passwords up to 15 symbols.
  localparam int unsigned CNT_W = 4;

  typedef enum logic {
    PATH_OK  = 1'b0,
    PATH_ERR = 1'b1
  } path_e;

  typedef struct packed {
    path_e            path;
    logic [CNT_W-1:0] depth;
  } lock_state_t;

  localparam lock_state_t START_STATE = '{path: PATH_OK, depth: '0};

  // True when the state is a final one (all symbols taken).
  function automatic logic is_final(lock_state_t s, int unsigned steps);
    return s.depth == CNT_W'(steps);
  endfunction

  // Advance one symbol along the current path, or fork into the error path.
  function automatic lock_state_t advance(lock_state_t s, logic good);
    lock_state_t r;
    r.depth = s.depth + 1'b1;
    r.path  = (s.path == PATH_OK && good) ? PATH_OK : PATH_ERR;
    return r;
  endfunction
endpackage

// File: rtl/lock_sym_match.sv
module lock_sym_match
  import lock_pkg::*;
#(
  parameter int unsigned SYM_W = 2,
  parameter int unsigned STEPS = 4,
  parameter logic [STEPS*SYM_W-1:0] CODE = '0
) (
  input  logic [SYM_W-1:0] sym,
  input  logic [CNT_W-1:0] depth,
  output logic             match
);
  localparam int unsigned CODE_W = STEPS * SYM_W;

  logic [SYM_W-1:0] per_step [STEPS];

  generate
    for (genvar i = 0; i < STEPS; i++) begin : g_slot
      assign per_step[i] = CODE[i*SYM_W +: SYM_W];
    end
  endgenerate

  logic [SYM_W-1:0] want;
  always_comb begin
    want = '0;
    for (int i = 0; i < STEPS; i++) begin
      if (depth == CNT_W'(i)) want = per_step[i];
    end
  end

  assign match = (sym == want) && (CODE_W != 0);
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import lock_pkg::*;
#(
  parameter int unsigned STEPS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strobe,
  input  logic        restart,
  input  logic        match,
  output lock_state_t cur,
  output lock_state_t nxt,
  output logic        step_ok,
  output logic        step_bad,
  output logic        err_adv,
  output logic        restart_take
);
  logic term;
  logic live;

  assign term         = is_final(cur, STEPS);
  assign live         = strobe && !term;
  assign restart_take = restart && term;
  assign step_ok      = live && cur.path == PATH_OK && match;
  assign step_bad     = live && cur.path == PATH_OK && !match;
  assign err_adv      = live && cur.path == PATH_ERR;

  always_comb begin
    nxt = cur;
    if (restart_take)
      nxt = START_STATE;
    else if (live)
      nxt = advance(cur, step_ok);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur <= START_STATE;
    else        cur <= nxt;
  end
endmodule

// File: rtl/lock_outreg.sv
module lock_outreg
  import lock_pkg::*;
#(
  parameter int unsigned STEPS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  lock_state_t nxt,
  output logic        open_o,
  output logic        error_o
);
  logic fin;
  assign fin = is_final(nxt, STEPS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_o  <= 1'b0;
      error_o <= 1'b0;
    end else begin
      open_o  <= fin && nxt.path == PATH_OK;
      error_o <= fin && nxt.path == PATH_ERR;
    end
  end
endmodule

// File: rtl/seq_code_lock.sv
module seq_code_lock
  import lock_pkg::*;
#(
  parameter int unsigned SYM_W = 2,
  parameter int unsigned STEPS = 4,
  parameter logic [STEPS*SYM_W-1:0] CODE = 8'b00_11_01_10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [SYM_W-1:0] keys,
  input  logic             restart,
  output logic             open_o,
  output logic             error_o
);
  lock_state_t      cur_w;
  lock_state_t      nxt_w;
  logic             match_w;
  logic             step_ok_w;
  logic             step_bad_w;
  logic             err_adv_w;
  logic             restart_take_w;
  logic             in_err_w;
  logic [CNT_W-1:0] depth_w;

  assign in_err_w = cur_w.path == PATH_ERR;
  assign depth_w  = cur_w.depth;

  lock_sym_match #(.SYM_W(SYM_W), .STEPS(STEPS), .CODE(CODE)) u_match (
    .sym   (keys),
    .depth (cur_w.depth),
    .match (match_w)
  );

  lock_fsm #(.STEPS(STEPS)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .restart      (restart),
    .match        (match_w),
    .cur          (cur_w),
    .nxt          (nxt_w),
    .step_ok      (step_ok_w),
    .step_bad     (step_bad_w),
    .err_adv      (err_adv_w),
    .restart_take (restart_take_w)
  );

  lock_outreg #(.STEPS(STEPS)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .nxt     (nxt_w),
    .open_o  (open_o),
    .error_o (error_o)
  );
endmodule

// File: rtl/lock_chk.sv
module lock_chk
  import lock_pkg::*;
#(
  parameter int unsigned STEPS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             strobe,
  input logic             restart,
  input logic             open_o,
  input logic             error_o,
  input logic             step_ok,
  input logic             step_bad,
  input logic             err_adv,
  input logic             restart_take,
  input logic             in_err,
  input logic [CNT_W-1:0] depth
);
  assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({open_o, error_o}));

  assert_open_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    open_o |-> (depth == CNT_W'(STEPS) && !in_err));

  assert_err_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> (depth == CNT_W'(STEPS) && in_err));

  assert_depth_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok || step_bad || err_adv) |=> depth == $past(depth) + 1'b1);

  assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !restart) |=> ($stable(depth) && $stable(in_err)));

  assert_bad_enters_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_bad |=> (in_err && !open_o));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_err && !restart_take) |=> in_err);

  assert_open_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o && !restart) |=> open_o);

  assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (error_o && !restart) |=> error_o);

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((open_o || error_o) && restart) |=> (!open_o && !error_o && depth == '0 && !in_err));

  assert_midrestart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !strobe && !open_o && !error_o) |=> $stable(depth));
endmodule

bind seq_code_lock lock_chk #(.STEPS(STEPS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .strobe       (strobe),
  .restart      (restart),
  .open_o       (open_o),
  .error_o      (error_o),
  .step_ok      (step_ok_w),
  .step_bad     (step_bad_w),
  .err_adv      (err_adv_w),
  .restart_take (restart_take_w),
  .in_err       (in_err_w),
  .depth        (depth_w)
);

// File: tb/tb_seq_code_lock.sv
module tb_seq_code_lock;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0;
  logic [1:0] keys = 2'b00;
  logic       restart = 1'b0;
  logic       open_o;
  logic       error_o;

  always #5 clk = ~clk;

  seq_code_lock dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .keys    (keys),
    .restart (restart),
    .open_o  (open_o),
    .error_o (error_o)
  );

  typedef struct {
    logic  op;
    logic  er;
    string req;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  // Bench model of the lock, written from the requirements.
  logic [1:0] pw [4] = '{2'b10, 2'b01, 2'b11, 2'b00};
  int   m_depth = 0;
  bit   m_err = 1'b0;

  task automatic model(input bit stb, input logic [1:0] s, input bit rs);
    if (rs && m_depth == 4) begin
      m_depth = 0;
      m_err   = 1'b0;
    end else if (stb && m_depth < 4) begin
      if (m_err || s != pw[m_depth]) m_err = 1'b1;
      m_depth++;
    end
  endtask

  // Driver: apply one cycle of stimulus and push the expected outputs.
  task automatic act(input bit stb, input logic [1:0] s, input bit rs, input string req);
    exp_t e;
    @(negedge clk);
    strobe  = stb;
    keys    = s;
    restart = rs;
    model(stb, s, rs);
    @(posedge clk);
    e.op  = (m_depth == 4) && !m_err;
    e.er  = (m_depth == 4) && m_err;
    e.req = req;
    q.push_back(e);
    @(negedge clk);
    strobe  = 1'b0;
    restart = 1'b0;
  endtask

  task automatic sym(input logic [1:0] s, input string req);
    act(1'b1, s, 1'b0, req);
  endtask

  // Monitor: compare outputs away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (open_o !== e.op || error_o !== e.er) begin
          n_fail++;
          $display("FAIL %s: open/error = %b%b, expected %b%b", e.req, open_o, error_o, e.op, e.er);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    act(1'b0, 2'b00, 1'b0, "R1 reset state");

    // R2 / R10: the correct password opens the lock, and the intermediate steps stay closed
    sym(2'b10, "R2 step0"); sym(2'b01, "R2 step1");
    sym(2'b11, "R2 step2"); sym(2'b00, "R2 open R10");
    // R7: a strobe while open is ignored
    sym(2'b10, "R7 strobe in open");
    sym(2'b11, "R7 strobe in open");
    act(1'b0, 2'b00, 1'b1, "R8 restart from open");

    // R3: idle cycles between symbols change nothing
    sym(2'b10, "R3 step0");
    act(1'b0, 2'b01, 1'b0, "R3 idle");
    act(1'b0, 2'b11, 1'b0, "R3 idle");
    sym(2'b01, "R3 step1");
    sym(2'b11, "R3 step2");
    act(1'b0, 2'b00, 1'b0, "R3 idle");
    sym(2'b00, "R3 open");
    act(1'b0, 2'b00, 1'b1, "R8 restart");

    // R4 R5 R6: wrong first symbol, then the correct tail is still consumed
    sym(2'b11, "R4 wrong first");
    sym(2'b01, "R6 correct after error");
    sym(2'b11, "R5 no early error");
    sym(2'b00, "R5 error at fourth");
    sym(2'b00, "R7 strobe in error");
    // R8: restart together with a strobe; the strobe must not count
    act(1'b1, 2'b10, 1'b1, "R8 restart wins over strobe");
    sym(2'b10, "R8 step0 after restart");
    sym(2'b01, "R8 step1");
    sym(2'b11, "R8 step2");
    sym(2'b00, "R8 opens after restart");
    act(1'b0, 2'b00, 1'b1, "R8 restart");

    // R4: wrong last symbol
    sym(2'b10, "R4 s0"); sym(2'b01, "R4 s1"); sym(2'b11, "R4 s2");
    sym(2'b01, "R4 wrong last gives error R5");
    act(1'b0, 2'b00, 1'b1, "R8 restart from error");

    // R4: wrong middle symbol
    sym(2'b10, "R4 s0"); sym(2'b00, "R4 wrong middle");
    sym(2'b11, "R6 tail"); sym(2'b00, "R5 error");
    act(1'b0, 2'b00, 1'b1, "R8 restart");

    // R9: restart mid-entry is ignored
    sym(2'b10, "R9 s0"); sym(2'b01, "R9 s1");
    act(1'b0, 2'b00, 1'b1, "R9 restart mid-entry");
    sym(2'b11, "R9 s2"); sym(2'b00, "R9 opens after ignored restart");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule